// File: doc/BRIEF.md
# Packet Store Log and Commit

This block holds the scalar stores that one issue packet of a wide-issue processor produces, at most one per memory slot (slot 0 and slot 1), and writes them to memory only when the packet ends. Each slot's log entry keeps a word address, a byte-enable and data already moved into its byte lanes. Predicated instructions that turn out false raise a per-slot cancel bit, and a cancelled slot never reaches memory.

Within a packet the pipeline may issue a load. A load in slot 0 must see the slot-1 store of the same packet. When slot 1 holds a live store, the block writes that store first, then reads. At packet end the slot-1 store goes out before the slot-0 store, and a slot-1 store that was already written for a load is skipped.

A new packet is opened with a start pulse, which clears the log and the cancel bits. An end pulse starts the commit. A one-cycle done pulse marks the point where the block is idle and will take the next start.

Top module: `pkt_store_commit`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_we, mem_re, ld_done and commit_done are all 0.
- R2: A log write whose zero-byte flag is set leaves its slot empty, and that slot writes nothing at commit. A log write with the flag clear makes its slot write once at commit.
- R3: The commit uses fixed cycles. The slot-1 write (if any) appears in the first cycle after the cycle that carries pkt_end. The slot-0 write (if any) appears in the second cycle after it.
- R4: When a slot's cancel bit is set in a packet, that slot writes nothing in that packet, neither early nor at commit.
- R5: pkt_start clears both log entries and both cancel bits. Nothing logged or cancelled in one packet affects the next.
- R6: Case: a slot-0 load (ld_slot=0) is requested while slot 1 holds an uncancelled store. The slot-1 write appears in the first cycle after ld_req, and mem_re for the load word appears in the second cycle after it.
- R7: Any other load (slot 1, or slot 0 with no live slot-1 store) drives mem_re in the first cycle after ld_req, and no write comes before it.
- R8: A slot-1 store that was written early for a load is not written again at commit.
- R9: A store has a size code sz, with bytes = 1 << sz (0:1, 1:2, 2:4, 3:8), and a byte address of naturally aligned offset o = addr[2:0]. It writes word addr[AW-1:3] with mem_be bits o to o+bytes-1 set. Data byte k of the logged value appears on mem_wdata byte lane o+k.
- R10: commit_done is high for exactly one cycle, the third cycle after the pkt_end cycle. pkt_start is ignored from the cycle after the start until commit_done. While no packet is open, log writes, cancels, loads and pkt_end are ignored.
- R11: ld_done is high for one cycle, the cycle after mem_re. In that cycle ld_data equals the memory word read, including any early slot-1 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Opens a packet (taken only when idle) |
| pkt_end | input | 1 | Starts the commit of the open packet |
| log_vld | input | 2 | Per-slot log write strobe |
| log_nobytes | input | 2 | Per-slot zero-byte store flag |
| log_addr | input | 2 x AW | Per-slot byte address |
| log_size | input | 2 x 2 | Per-slot size code (bytes = 1 << code) |
| log_data | input | 2 x 64 | Per-slot store data, right-aligned |
| cancel_set | input | 2 | Per-slot cancel mask, OR-ed into the cancel bits |
| ld_req | input | 1 | Load request |
| ld_slot | input | 1 | Slot of the load |
| ld_word | input | AW-3 | Word address of the load |
| ld_done | output | 1 | Load data valid |
| ld_data | output | 64 | Load data word |
| commit_done | output | 1 | Packet commit finished pulse |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW-3 | Memory word address |
| mem_be | output | 8 | Memory byte enables |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid the cycle after mem_re |

## Verification
The assertions take for granted that the inputs follow these rules:
- A store address is naturally aligned to its size.
- ld_req and pkt_end never fall in the same cycle.
- No slot-1 log write or cancel falls in the same cycle as a slot-0 load request, because a store logged in that cycle is not seen by the load's ordering decision.
- The memory returns read data one cycle after mem_re.

The stimulus follows the same fixed sequence in every packet: start, then one cycle of logs and cancels, then an optional load, then the end pulse. Random addresses are forced onto size-aligned offsets within a few words, so that loads and stores often share a word.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int PSC_SLOTS = 2;
  localparam int PSC_DW    = 64;
  localparam int PSC_NB    = PSC_DW / 8;
  localparam int PSC_OW    = $clog2(PSC_NB);
  localparam int PSC_SZW   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_LDWR, ST_LDRD, ST_LDRSP, ST_CMT1, ST_CMT0, ST_DONE
  } psc_state_e;

  // Right-aligned mask of the bytes a size code covers.
  function automatic logic [PSC_NB-1:0] size_mask(logic [PSC_SZW-1:0] sz);
    logic [PSC_NB:0] t;
    t = ((PSC_NB+1)'(1) << (32'd1 << sz)) - (PSC_NB+1)'(1);
    return t[PSC_NB-1:0];
  endfunction

  function automatic logic [PSC_NB-1:0] byte_en(logic [PSC_SZW-1:0] sz,
                                                 logic [PSC_OW-1:0] ofs);
    return size_mask(sz) << ofs;
  endfunction

  // Keeps the covered bytes and moves them to their lanes.
  function automatic logic [PSC_DW-1:0] lane_data(logic [PSC_DW-1:0] d,
                                                   logic [PSC_SZW-1:0] sz,
                                                   logic [PSC_OW-1:0] ofs);
    logic [PSC_NB-1:0] m;
    logic [PSC_DW-1:0] k;
    m = size_mask(sz);
    for (int i = 0; i < PSC_NB; i++) begin
      k[8*i +: 8] = m[i] ? d[8*i +: 8] : 8'h00;
    end
    return k << {ofs, 3'b000};
  endfunction
endpackage

// File: rtl/psc_slot.sv
module psc_slot
  import psc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     log_en,
  input  logic                     log_nobytes,
  input  logic [AW-1:0]            log_addr,
  input  logic [PSC_SZW-1:0]       log_size,
  input  logic [PSC_DW-1:0]        log_data,
  input  logic                     cancel,
  input  logic                     retire,
  output logic                     pend,
  output logic [AW-PSC_OW-1:0]     word,
  output logic [PSC_NB-1:0]        be,
  output logic [PSC_DW-1:0]        wdata
);
  logic held_q, kill_q, done_q;
  logic [PSC_OW-1:0] ofs;

  assign ofs = log_addr[PSC_OW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      kill_q <= 1'b0;
      done_q <= 1'b0;
      word   <= '0;
      be     <= '0;
      wdata  <= '0;
    end else if (clr) begin
      held_q <= 1'b0;
      kill_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (log_en && !log_nobytes) begin
        held_q <= 1'b1;
        word   <= log_addr[AW-1:PSC_OW];
        be     <= byte_en(log_size, ofs);
        wdata  <= lane_data(log_data, log_size, ofs);
      end
      if (cancel) kill_q <= 1'b1;
      if (retire) done_q <= 1'b1;
    end
  end

  assign pend = held_q && !kill_q && !done_q;

  AST_RETIRE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (held_q && !kill_q)); // R4
  AST_RETIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire || clr || $past(clr)); // R8
endmodule

// File: rtl/psc_seq.sv
module psc_seq
  import psc_pkg::*;
#(
  parameter int WAW = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_start,
  input  logic                  pkt_end,
  input  logic                  ld_req,
  input  logic                  ld_slot,
  input  logic [WAW-1:0]        ld_word,
  input  logic [PSC_SLOTS-1:0]  pend,
  output logic                  accept,
  output logic                  clr,
  output logic                  wr_go,
  output logic                  wr_slot,
  output logic                  rd_go,
  output logic [WAW-1:0]        rd_word,
  output logic                  ld_done,
  output logic                  commit_done
);
  psc_state_e st_q, st_d;
  logic       ld_slot_q;
  logic       flush_now;

  assign flush_now = !ld_slot && pend[1];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (pkt_start) st_d = ST_OPEN;
      ST_OPEN:  if (ld_req) st_d = flush_now ? ST_LDWR : ST_LDRD;
                else if (pkt_end) st_d = ST_CMT1;
      ST_LDWR:  st_d = ST_LDRD;
      ST_LDRD:  st_d = ST_LDRSP;
      ST_LDRSP: st_d = ST_OPEN;
      ST_CMT1:  st_d = ST_CMT0;
      ST_CMT0:  st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ld_slot_q <= 1'b0;
      rd_word   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_OPEN && ld_req) begin
        ld_slot_q <= ld_slot;
        rd_word   <= ld_word;
      end
    end
  end

  assign accept      = (st_q == ST_OPEN);
  assign clr         = (st_q == ST_IDLE) && pkt_start;
  assign wr_go       = ((st_q == ST_LDWR || st_q == ST_CMT1) && pend[1]) ||
                       (st_q == ST_CMT0 && pend[0]);
  assign wr_slot     = (st_q != ST_CMT0);
  assign rd_go       = (st_q == ST_LDRD);
  assign ld_done     = (st_q == ST_LDRSP);
  assign commit_done = (st_q == ST_DONE);

  AST_SLOT0_AFTER_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !wr_slot) |-> !pend[1]); // R3
  AST_LOAD_SEES_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !ld_slot_q) |-> !pend[1]); // R6
  AST_ONE_PORT_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && rd_go)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !commit_done); // R10
endmodule

// File: rtl/pkt_store_commit.sv
module pkt_store_commit
  import psc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 pkt_start,
  input  logic                                 pkt_end,
  input  logic [PSC_SLOTS-1:0]                 log_vld,
  input  logic [PSC_SLOTS-1:0]                 log_nobytes,
  input  logic [PSC_SLOTS-1:0][AW-1:0]         log_addr,
  input  logic [PSC_SLOTS-1:0][PSC_SZW-1:0]    log_size,
  input  logic [PSC_SLOTS-1:0][PSC_DW-1:0]     log_data,
  input  logic [PSC_SLOTS-1:0]                 cancel_set,
  input  logic                                 ld_req,
  input  logic                                 ld_slot,
  input  logic [AW-PSC_OW-1:0]                 ld_word,
  output logic                                 ld_done,
  output logic [PSC_DW-1:0]                    ld_data,
  output logic                                 commit_done,
  output logic                                 mem_we,
  output logic                                 mem_re,
  output logic [AW-PSC_OW-1:0]                 mem_addr,
  output logic [PSC_NB-1:0]                    mem_be,
  output logic [PSC_DW-1:0]                    mem_wdata,
  input  logic [PSC_DW-1:0]                    mem_rdata
);
  localparam int WAW = AW - PSC_OW;

  logic                   accept, clr, wr_go, wr_slot, rd_go;
  logic [WAW-1:0]         rd_word;
  logic [PSC_SLOTS-1:0]   pend;
  logic [WAW-1:0]         s_word  [PSC_SLOTS];
  logic [PSC_NB-1:0]      s_be    [PSC_SLOTS];
  logic [PSC_DW-1:0]      s_wdata [PSC_SLOTS];

  psc_seq #(.WAW(WAW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_start  (pkt_start),
    .pkt_end    (pkt_end),
    .ld_req     (ld_req),
    .ld_slot    (ld_slot),
    .ld_word    (ld_word),
    .pend       (pend),
    .accept     (accept),
    .clr        (clr),
    .wr_go      (wr_go),
    .wr_slot    (wr_slot),
    .rd_go      (rd_go),
    .rd_word    (rd_word),
    .ld_done    (ld_done),
    .commit_done(commit_done)
  );

  for (genvar s = 0; s < PSC_SLOTS; s++) begin : g_slot
    psc_slot #(.AW(AW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .log_en     (accept && log_vld[s]),
      .log_nobytes(log_nobytes[s]),
      .log_addr   (log_addr[s]),
      .log_size   (log_size[s]),
      .log_data   (log_data[s]),
      .cancel     (accept && cancel_set[s]),
      .retire     (wr_go && (wr_slot == (s == 1))),
      .pend       (pend[s]),
      .word       (s_word[s]),
      .be         (s_be[s]),
      .wdata      (s_wdata[s])
    );
  end

  assign mem_we    = wr_go;
  assign mem_re    = rd_go;
  assign mem_addr  = rd_go ? rd_word : s_word[wr_slot];
  assign mem_be    = wr_go ? s_be[wr_slot] : '0;
  assign mem_wdata = s_wdata[wr_slot];
  assign ld_data   = mem_rdata;

  AST_BE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) inside {1, 2, 4, 8})); // R9
endmodule

// File: tb/sim_pkt_store_commit.sv
module sim_pkt_store_commit;
  localparam int AW = 12;
  localparam int WAW = AW - 3;
  localparam int NW = 1 << WAW;

  logic clk = 1'b0;
  logic rst_n;
  logic pkt_start, pkt_end, ld_req, ld_slot;
  logic [1:0] log_vld, log_nobytes, cancel_set;
  logic [1:0][AW-1:0] log_addr;
  logic [1:0][1:0] log_size;
  logic [1:0][63:0] log_data;
  logic [WAW-1:0] ld_word;
  logic ld_done, commit_done, mem_we, mem_re;
  logic [63:0] ld_data, mem_wdata, mem_rdata;
  logic [WAW-1:0] mem_addr;
  logic [7:0] mem_be;

  logic [63:0] mem [NW];
  logic [63:0] refm [NW];
  int checks = 0;
  int errors = 0;

  // packet description
  logic        p_v[2], p_nb[2], p_cx[2];
  logic [AW-1:0] p_addr[2];
  logic [1:0]  p_sz[2];
  logic [63:0] p_d[2];
  logic        p_ld, p_ldsl, p_poke;
  logic [WAW-1:0] p_ldw;

  always #5 clk = ~clk;

  pkt_store_commit #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .log_vld(log_vld), .log_nobytes(log_nobytes), .log_addr(log_addr),
    .log_size(log_size), .log_data(log_data), .cancel_set(cancel_set),
    .ld_req(ld_req), .ld_slot(ld_slot), .ld_word(ld_word),
    .ld_done(ld_done), .ld_data(ld_data), .commit_done(commit_done),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_we)
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [7:0] b_be(logic [1:0] sz, logic [2:0] o);
    logic [7:0] r = 8'h00;
    int n = 1 << sz;
    for (int i = 0; i < 8; i++) if (i >= o && i < o + n) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] b_lane(logic [63:0] d, logic [1:0] sz, logic [2:0] o);
    logic [63:0] r = '0;
    int n = 1 << sz;
    for (int i = 0; i < 8; i++)
      if (i >= o && i < o + n) r[8*i +: 8] = d[8*(i - o) +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_apply(input int s);
    logic [7:0] be = b_be(p_sz[s], p_addr[s][2:0]);
    logic [63:0] ln = b_lane(p_d[s], p_sz[s], p_addr[s][2:0]);
    for (int b = 0; b < 8; b++)
      if (be[b]) refm[p_addr[s][AW-1:3]][8*b +: 8] = ln[8*b +: 8];
  endtask

  task automatic chk_write(input int s, input string req);
    logic [127:0] a, e;
    a = {mem_we, mem_addr, mem_be, mem_wdata};
    e = {1'b1, p_addr[s][AW-1:3], b_be(p_sz[s], p_addr[s][2:0]),
         b_lane(p_d[s], p_sz[s], p_addr[s][2:0])};
    chk(a == e, req, a, e);
  endtask

  task automatic idle_inputs();
    pkt_start = 0; pkt_end = 0; ld_req = 0; ld_slot = 0; ld_word = '0;
    log_vld = 0; log_nobytes = 0; cancel_set = 0;
    log_addr = '0; log_size = '0; log_data = '0;
  endtask

  task automatic run_pkt();
    logic live[2];
    bit early = 0;
    for (int s = 0; s < 2; s++) live[s] = p_v[s] && !p_nb[s] && !p_cx[s];
    @(negedge clk); pkt_start = 1;
    @(negedge clk); pkt_start = 0;
    for (int s = 0; s < 2; s++) begin
      log_vld[s] = p_v[s]; log_nobytes[s] = p_nb[s]; log_addr[s] = p_addr[s];
      log_size[s] = p_sz[s]; log_data[s] = p_d[s]; cancel_set[s] = p_cx[s];
    end
    @(negedge clk); log_vld = 0; log_nobytes = 0; cancel_set = 0;
    if (p_ld) begin
      ld_req = 1; ld_slot = p_ldsl; ld_word = p_ldw;
      early = !p_ldsl && live[1];
      @(negedge clk); ld_req = 0;
      if (early) begin
        chk_write(1, "R6 early slot-1 write");
        ref_apply(1);
        @(negedge clk);
      end else begin
        chk(mem_we == 0, "R7 no write before load", mem_we, 0);
      end
      chk(mem_re && mem_addr == p_ldw, early ? "R6 read after flush" : "R7 read",
          {mem_re, mem_addr}, {1'b1, p_ldw});
      @(negedge clk);
      chk(ld_done && ld_data == refm[p_ldw], "R11 load data",
          {ld_done, ld_data}, {1'b1, refm[p_ldw]});
      @(negedge clk);
      chk(ld_done == 0, "R11 load pulse", ld_done, 0);
    end
    pkt_end = 1;
    @(negedge clk); pkt_end = 0;
    if (p_poke) pkt_start = 1;
    if (live[1] && !early) begin
      chk_write(1, "R3 slot-1 commit first");
      ref_apply(1);
    end else chk(mem_we == 0, early ? "R8 no second write" : "R4/R2 slot-1 silent", mem_we, 0);
    @(negedge clk); pkt_start = 0;
    if (live[0]) begin
      chk_write(0, "R3 slot-0 commit second");
      ref_apply(0);
    end else chk(mem_we == 0, "R4/R2 slot-0 silent", mem_we, 0);
    chk(commit_done == 0, "R10 done not early", commit_done, 0);
    @(negedge clk);
    chk(commit_done == 1 && mem_we == 0, "R10 done pulse", {commit_done, mem_we}, 2'b10);
    @(negedge clk);
    chk(commit_done == 0, "R10 done single", commit_done, 0);
    for (int s = 0; s < 2; s++)
      chk(mem[p_addr[s][AW-1:3]] == refm[p_addr[s][AW-1:3]], "R2 memory contents",
          mem[p_addr[s][AW-1:3]], refm[p_addr[s][AW-1:3]]);
  endtask

  task automatic clear_pkt();
    for (int s = 0; s < 2; s++) begin
      p_v[s] = 0; p_nb[s] = 0; p_cx[s] = 0; p_addr[s] = '0; p_sz[s] = 0; p_d[s] = '0;
    end
    p_ld = 0; p_ldsl = 0; p_ldw = '0; p_poke = 0;
  endtask

  task automatic set_store(input int s, input int w, input int o, input int sz, input logic [63:0] d);
    p_v[s] = 1; p_sz[s] = 2'(sz);
    p_addr[s] = {WAW'(w), 3'(o)};
    p_d[s] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < NW; i++) begin
      mem[i] = {$urandom, $urandom};
      refm[i] = mem[i];
    end
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk({mem_we, mem_re, ld_done, commit_done} == 0, "R1 reset quiet",
        {mem_we, mem_re, ld_done, commit_done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({mem_we, mem_re, ld_done, commit_done} == 0, "R1 after reset",
        {mem_we, mem_re, ld_done, commit_done}, 0);

    // R6 R8 R11: slot-0 load on the word of a live slot-1 store
    clear_pkt();
    set_store(1, 3, 4, 2, 64'h1122334455667788);
    set_store(0, 5, 0, 3, 64'hA5A5A5A5_5A5A5A5A);
    p_ld = 1; p_ldsl = 0; p_ldw = 3;
    run_pkt();

    // R2 R7: zero-byte slot-1 store does not force an early write
    clear_pkt();
    set_store(1, 3, 0, 3, 64'hDEAD);
    p_nb[1] = 1;
    p_ld = 1; p_ldw = 3;
    run_pkt();

    // R4 R7: cancelled slot-1 store with a slot-0 load
    clear_pkt();
    set_store(1, 4, 2, 1, 64'hBEEF);
    set_store(0, 4, 0, 0, 64'h77);
    p_cx[1] = 1;
    p_ld = 1; p_ldw = 4;
    run_pkt();

    // R5: both cancelled, then next packet uncancelled
    clear_pkt();
    set_store(0, 6, 0, 3, 64'h1);
    set_store(1, 7, 0, 3, 64'h2);
    p_cx[0] = 1; p_cx[1] = 1;
    run_pkt();
    clear_pkt();
    set_store(0, 6, 1, 0, 64'hC3);
    set_store(1, 7, 6, 1, 64'h9A9B);
    run_pkt();
    // R5: empty packet after a logged one writes nothing
    clear_pkt();
    p_addr[0] = {WAW'(6), 3'd0}; p_addr[1] = {WAW'(7), 3'd0};
    run_pkt();

    // R9: every size code; R10 pkt_start poked during commit
    for (int sz = 0; sz < 4; sz++) begin
      clear_pkt();
      set_store(0, 8 + sz, (1 << sz) & 7, sz, 64'h0102030405060708);
      set_store(1, 12, 0, sz, 64'hF0E0D0C0B0A09080);
      p_poke = (sz == 2);
      run_pkt();
    end

    // R10: after the poke, block is idle; logs and pkt_end are ignored
    @(negedge clk);
    log_vld = 2'b11; log_addr[0] = 12'h010; log_addr[1] = 12'h018;
    log_size[0] = 2'd3; log_size[1] = 2'd3; pkt_end = 1; ld_req = 1;
    @(negedge clk); idle_inputs();
    for (int k = 0; k < 4; k++) begin
      chk({mem_we, mem_re, commit_done, ld_done} == 0, "R10 idle ignores requests",
          {mem_we, mem_re, commit_done, ld_done}, 0);
      @(negedge clk);
    end

    // random packets
    for (int n = 0; n < 300; n++) begin
      clear_pkt();
      for (int s = 0; s < 2; s++) begin
        int sz = $urandom_range(0, 3);
        int o = $urandom_range(0, 7) & ~((1 << sz) - 1);
        p_v[s] = ($urandom_range(0, 3) != 0);
        p_nb[s] = ($urandom_range(0, 7) == 0);
        p_cx[s] = ($urandom_range(0, 3) == 0);
        p_sz[s] = 2'(sz);
        p_addr[s] = {WAW'($urandom_range(0, 15)), 3'(o)};
        p_d[s] = {$urandom, $urandom};
      end
      p_ld = ($urandom_range(0, 1) == 1);
      p_ldsl = ($urandom_range(0, 2) == 0);
      p_ldw = ($urandom_range(0, 1) == 1) ? p_addr[1][AW-1:3] : WAW'($urandom_range(0, 15));
      run_pkt();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule